// File: doc/BRIEF.md
# Incremental Sigma-Delta Interval Decoder

This block turns the one-bit stream of a first-order incremental sigma-delta modulator into a fixed-point estimate of the constant input that produced it. It assumes the modulator integrator is cleared at the start of each conversion and that the input lies in [0, 1] and stays constant throughout. A conversion is opened with a start pulse that also gives its length m. Each bit then arrives with a valid strobe. The block narrows a pair of fractional bounds that must enclose the input. Once m bits are in, it emits the midpoint of the final interval.

The bounds are held as exact numerator/denominator pairs. During the conversion they are updated only by comparing cross products. The one division happens after the last bit. A sequential restoring divider produces the midpoint to `FRAC_W` fraction bits plus one integer bit. A single-cycle done pulse marks the result, and the result is then held until the next start. A start pulse at any time abandons the running conversion.

Top module: `sd_interval_decoder`

## Requirements
- R1: After reset, and in the cycle after any start pulse, `est_o` is 0 and `done_o` is 0.
- R2: A bit of 1 accepted as sample p (counting from 1) raises the lower bound to the larger of itself and c/p. The running count c starts at 1 on each start, and is then incremented by one.
- R3: A bit of 0 accepted as sample p lowers the upper bound to the smaller of itself and c/p, and leaves c unchanged. The bounds start at 0 (lower) and 1 (upper).
- R4: The result `est_o` is floor(2^FRAC_W · (lower + upper) / 2). It is an unsigned value whose MSB has weight 1 and whose remaining FRAC_W bits are fractional.
- R5: The bits 0,0,1,0,1 in time order with m = 5 give the interval [2/5, 1/2] and the estimate 9/20, which is 1843 at FRAC_W = 12.
- R6: `done_o` rises no more than FRAC_W+3 clock cycles after the m-th bit is accepted and stays high for exactly one cycle. `est_o` then keeps its value until the next start.
- R7: A bit presented while `bit_vld_i` is low is ignored. A bit presented after m bits have been accepted, or before any start, is also ignored: it changes neither `est_o` nor `done_o`.
- R8: A start pulse aborts a conversion in progress, including one in its division phase. The new conversion's result depends only on bits accepted after that start.
- R9: With m = 0 the estimate is 1/2. With every bit equal to 1 the estimate is 1.0 (2^FRAC_W). With every bit equal to 0 the estimate is 1/(2m).
- R10: For a bit stream produced by an ideal first-order incremental modulator from a constant rational input x in (0, 1], the estimate is the midpoint of the two neighbouring fractions q/p (0 ≤ q ≤ p ≤ m) that enclose x: the largest below x and the smallest at or above x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a new conversion; clears all state |
| conv_len_i | input | LEN_W | Conversion length m, sampled with `start_i` (at most MAX_LEN) |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| bit_i | input | 1 | Modulator output bit |
| est_o | output | FRAC_W+1 | Midpoint estimate, one integer bit and FRAC_W fraction bits |
| done_o | output | 1 | One-cycle pulse when `est_o` becomes valid |

## Verification
The bench drives streams from an ideal modulator model over a table of rational inputs and lengths. It compares each result with the enclosing pair of fractions, found by brute-force search rather than by tracking bounds. A decoder with a strict/non-strict comparison swapped, or with the count advanced on a 0, lands in a neighbouring interval and shows up there. Several directed tests each target one way the design could go wrong:
- The all-ones stream catches a divider without an integer quotient bit, which would wrap the estimate of 1.0 to 0.
- The m = 0 case catches a sequencer that waits forever or divides by zero.
- Extra bits after m catch a design that keeps counting and fires a second done.
- A start during division catches a divider that is not cleared and delivers a stale result.

// File: rtl/sd_dec_pkg.sv
// Package: shared sequencing type for the incremental sigma-delta interval
// decoder. Assumes nothing beyond the synthesizable subset.
package sd_dec_pkg;

    // Conversion phases seen by the top-level sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // no conversion opened since reset
        PH_RUN  = 2'd1,   // accepting modulator bits
        PH_DIV  = 2'd2,   // midpoint division in progress
        PH_HOLD = 2'd3    // result delivered, waiting for next start
    } phase_t;

endpackage

// File: rtl/sd_bound_tracker.sv
// Module: sd_bound_tracker
// Tracks the interval [lo_n/lo_d, hi_n/hi_d] that must contain the modulator
// input. Each accepted bit compares the running count over the sample index
// with one bound by cross multiplication, so no division is needed.
// Assumes every numerator and denominator stays below 2**LW.
module sd_bound_tracker #(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic          bit_in,
    output logic [LW-1:0] lo_n,
    output logic [LW-1:0] lo_d,
    output logic [LW-1:0] hi_n,
    output logic [LW-1:0] hi_d,
    output logic [LW-1:0] smp_cnt
);
    localparam int PW = 2 * LW;

    logic [LW-1:0] pred_q;
    logic [LW-1:0] idx;
    logic [PW-1:0] cand_x_lod, lon_x_idx, cand_x_hid, hin_x_idx;
    logic          raise_lo, cut_hi;

    // Sample index p of the bit being accepted (1-based).
    assign idx = smp_cnt + LW'(1);

    // Cross products that compare candidate pred/p with each bound.
    always_comb begin
        cand_x_lod = PW'(pred_q) * PW'(lo_d);
        lon_x_idx  = PW'(lo_n)   * PW'(idx);
        cand_x_hid = PW'(pred_q) * PW'(hi_d);
        hin_x_idx  = PW'(hi_n)   * PW'(idx);
        raise_lo   = cand_x_lod > lon_x_idx;
        cut_hi     = cand_x_hid < hin_x_idx;
    end

    // Bound, running-count and sample-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pred_q  <= LW'(1);
            smp_cnt <= '0;
            lo_n    <= '0;
            lo_d    <= LW'(1);
            hi_n    <= LW'(1);
            hi_d    <= LW'(1);
        end else if (upd) begin
            smp_cnt <= idx;
            if (bit_in) begin
                if (raise_lo) begin
                    lo_n <= pred_q;
                    lo_d <= idx;
                end
                pred_q <= pred_q + LW'(1);
            end else if (cut_hi) begin
                hi_n <= pred_q;
                hi_d <= idx;
            end
        end
    end

    // R2: the lower bound never falls on a 1 bit.
    p_lo_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && bit_in && !clr) |=>
        (PW'(lo_n) * PW'($past(lo_d)) >= PW'($past(lo_n)) * PW'(lo_d)));

    // R2: the running count steps by one on a 1 bit.
    p_pred_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && bit_in && !clr) |=> (pred_q == $past(pred_q) + LW'(1)));

    // R3: the upper bound never rises on a 0 bit.
    p_hi_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !bit_in && !clr) |=>
        (PW'(hi_n) * PW'($past(hi_d)) <= PW'($past(hi_n)) * PW'(hi_d)));

    // R3: the running count holds on a 0 bit.
    p_pred_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !bit_in && !clr) |=> $stable(pred_q));

    // R2: the running count never exceeds one plus the samples taken.
    p_pred_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_q <= smp_cnt + LW'(1));

endmodule

// File: rtl/sd_mid_divider.sv
// Module: sd_mid_divider
// Sequential restoring divider giving floor(num * 2**FW / den), one quotient
// bit per cycle with the integer bit first. Assumes num <= den and den != 0,
// so the quotient fits in FW+1 bits. A clear aborts the division.
module sd_mid_divider #(
    parameter int DW = 15,
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [FW:0]   res,
    output logic          done
);
    localparam int CW = $clog2(FW + 1) + 1;

    logic [DW:0]   rem_q;
    logic [DW:0]   den_q;
    logic [FW-1:0] quo_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          qbit;
    logic [DW:0]   rem_nx;

    // One restoring step: trial subtract, keep the remainder when it fits.
    always_comb begin
        qbit   = rem_q >= den_q;
        rem_nx = qbit ? rem_q - den_q : rem_q;
    end

    // Iteration state, result register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            res    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q  <= {1'b0, num};
                den_q  <= {1'b0, den};
                quo_q  <= '0;
                cnt_q  <= CW'(FW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= {rem_nx[DW-1:0], 1'b0};
                quo_q <= {quo_q[FW-2:0], qbit};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == '0) begin
                    res    <= {quo_q, qbit};
                    done   <= 1'b1;
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // R6: completion is a single-cycle pulse.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the quotient of a midpoint never exceeds 1.0.
    p_quot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res <= (FW+1)'(1) << FW));

endmodule

// File: rtl/sd_interval_decoder.sv
// Module: sd_interval_decoder (top)
// Optimal decoder for one conversion of a first-order incremental
// sigma-delta modulator: tracks the enclosing interval over m bits, then
// divides out its midpoint. Assumes conv_len_i <= MAX_LEN and a constant
// modulator input in [0, 1] during the conversion.
module sd_interval_decoder
    import sd_dec_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int FRAC_W  = 12,
    localparam int LEN_W  = $clog2(MAX_LEN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] conv_len_i,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    output logic [FRAC_W:0]  est_o,
    output logic             done_o
);
    localparam int DW = 2 * LEN_W + 1;

    phase_t          phase_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] lo_n, lo_d, hi_n, hi_d, smp_cnt;
    logic            accept, div_go;
    logic [DW-1:0]   mid_num, mid_den;

    // A bit is taken only while running and before m bits have been seen.
    assign accept = (phase_q == PH_RUN) && bit_vld_i && !start_i
                    && (smp_cnt < len_q);
    // Division starts once the m-th bit is in the bounds.
    assign div_go = (phase_q == PH_RUN) && !start_i && (smp_cnt == len_q);

    // Midpoint as a single fraction: (lo_n*hi_d + hi_n*lo_d) / (2*lo_d*hi_d).
    always_comb begin
        mid_num = DW'(lo_n) * DW'(hi_d) + DW'(hi_n) * DW'(lo_d);
        mid_den = (DW'(lo_d) * DW'(hi_d)) << 1;
    end

    // Conversion phase and captured length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            len_q   <= '0;
        end else if (start_i) begin
            phase_q <= PH_RUN;
            len_q   <= conv_len_i;
        end else begin
            case (phase_q)
                PH_RUN:  if (div_go) phase_q <= PH_DIV;
                PH_DIV:  if (done_o) phase_q <= PH_HOLD;
                default: phase_q <= phase_q;
            endcase
        end
    end

    sd_bound_tracker #(.LW(LEN_W)) u_bounds (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_i),
        .upd     (accept),
        .bit_in  (bit_i),
        .lo_n    (lo_n),
        .lo_d    (lo_d),
        .hi_n    (hi_n),
        .hi_d    (hi_d),
        .smp_cnt (smp_cnt)
    );

    sd_mid_divider #(.DW(DW), .FW(FRAC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_i),
        .go    (div_go),
        .num   (mid_num),
        .den   (mid_den),
        .res   (est_o),
        .done  (done_o)
    );

    // R7: never more samples than the conversion length.
    p_count_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |-> (smp_cnt <= len_q));

    // R7: outside the running phase, the sample count does not move.
    p_idle_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_RUN && !start_i) |=> $stable(smp_cnt));

    // R1: the cycle after a start shows no result and no done.
    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (est_o == '0 && !done_o));

    // R6: a result only appears out of the division phase.
    p_done_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (phase_q == PH_DIV));

endmodule

// File: tb/test_sd_interval_decoder.sv
module test_sd_interval_decoder;
    localparam int MAX_LEN = 64;
    localparam int FRAC_W  = 12;
    localparam int LEN_W   = $clog2(MAX_LEN + 2);
    localparam int NVEC    = 8;
    // Stimulus table: input x = VA/VB, length VM; expected from brute force.
    localparam int VA[NVEC] = '{1, 3, 2, 5, 1, 99, 7, 1};
    localparam int VB[NVEC] = '{3, 4, 5, 8, 100, 100, 9, 2};
    localparam int VM[NVEC] = '{7, 6, 10, 16, 64, 64, 33, 1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] conv_len_i = '0;
    logic             bit_vld_i = 1'b0;
    logic             bit_i = 1'b0;
    logic [FRAC_W:0]  est_o;
    logic             done_o;
    int n_chk = 0;
    int n_fail = 0;
    int extra_done;

    always #2 clk = ~clk;

    sd_interval_decoder #(.MAX_LEN(MAX_LEN), .FRAC_W(FRAC_W)) i_sd_interval_decoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .conv_len_i(conv_len_i),
        .bit_vld_i(bit_vld_i), .bit_i(bit_i), .est_o(est_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Enclosing neighbours of x=a/b among q/p, p<=m, then midpoint in fixed point.
    function automatic int ref_est(input int a, input int b, input int m);
        int ln = 0, ld = 1, hn = 1, hd = 1;
        for (int p = 1; p <= m; p++)
            for (int q = 0; q <= p; q++) begin
                if (q * b < a * p && q * ld > ln * p) begin ln = q; ld = p; end
                if (q * b >= a * p && q * hd < hn * p) begin hn = q; hd = p; end
            end
        return ((ln * hd + hn * ld) << FRAC_W) / (2 * ld * hd);
    endfunction

    task automatic do_start(input int len);
        start_i = 1'b1; conv_len_i = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        bit_vld_i = 1'b1; bit_i = b;
        @(negedge clk);
        bit_vld_i = 1'b0;
    endtask

    // Ideal modulator: bit n is 1 when n*x > 1 + ones so far; optional idle gaps.
    task automatic send_stream(input int a, input int b, input int m, input bit gaps);
        int ones = 0;
        for (int n = 1; n <= m; n++) begin
            logic bb = (n * a > b * (1 + ones));
            if (bb) ones++;
            send_bit(bb);
            if (gaps) begin bit_i = ~bb; @(negedge clk); @(negedge clk); end
        end
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
    endtask

    task automatic run_pattern(input string req, input int m, input int bits,
                               input int exp);
        int cyc;
        do_start(m);
        for (int i = 0; i < m; i++) send_bit(bits[i]);
        wait_done(cyc);
        check(req, done_o ? int'(est_o) : -1, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin : main
        int cyc, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset est", int'(est_o), 0);
        check("R1 reset done", int'(done_o), 0);

        // R7: bits before any start are ignored.
        send_bit(1'b1); send_bit(1'b0);
        check("R7 no done before start", int'(done_o), 0);

        // R10 / R2 / R3 / R4: table of modulator streams.
        for (int v = 0; v < NVEC; v++) begin
            do_start(VM[v]);
            send_stream(VA[v], VB[v], VM[v], 1'b0);
            wait_done(cyc);
            check("R10 table estimate", done_o ? int'(est_o) : -1,
                  ref_est(VA[v], VB[v], VM[v]));
            check("R6 latency", int'(cyc <= FRAC_W + 3), 1);
            @(negedge clk);
            check("R6 single-cycle done", int'(done_o), 0);
        end

        // R5: bits 0,0,1,0,1 (bit0 first) give 9/20.
        run_pattern("R5 known sequence", 5, 5'b10100, 1843);
        e = int'(est_o);

        // R7: extra bits after m change nothing.
        extra_done = 0;
        for (int i = 0; i < 6; i++) begin
            send_bit(i[0]);
            if (done_o) extra_done++;
        end
        check("R7 no done from extra bits", extra_done, 0);
        check("R6 R7 estimate held", int'(est_o), e);

        // R7: gaps with valid low and toggled data must not matter.
        do_start(12);
        send_stream(3, 7, 12, 1'b1);
        wait_done(cyc);
        check("R7 valid-low gaps", done_o ? int'(est_o) : -1, ref_est(3, 7, 12));

        // R9: corner lengths and patterns.
        run_pattern("R9 length zero", 0, 0, 1 << (FRAC_W - 1));
        run_pattern("R9 all ones", 8, 8'hFF, 1 << FRAC_W);
        run_pattern("R9 all zeros", 8, 0, (1 << FRAC_W) / 16);
        run_pattern("R3 single zero bit", 1, 0, 1 << (FRAC_W - 1));
        run_pattern("R2 single one bit", 1, 1, 1 << FRAC_W);

        // R8: abort during bit collection.
        do_start(8);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        run_pattern("R8 abort while running", 5, 5'b10100, 1843);

        // R8 / R1: abort during division.
        do_start(5);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        @(negedge clk); @(negedge clk); @(negedge clk);
        do_start(0);
        check("R1 est cleared by start", int'(est_o), 0);
        wait_done(cyc);
        check("R8 abort in division", done_o ? int'(est_o) : -1, 1 << (FRAC_W - 1));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule